// File: doc/BRIEF.md
# Battery Capacity Tracking Register File

This block holds the charge-state registers of a coulomb-counting battery gauge. A sense-resistor integrator upstream sends one step per charge quantum, with a direction bit. The block turns these steps into a saturating 16-bit available-capacity count. It keeps a rate-compensated capacity, which follows the count while charging and may only fall while discharging. It learns the full-to-empty capacity of the cell on a qualified discharge cycle, and a shared sequential divider derives the state of charge as an integer percentage of that learned capacity.

The rate-compensated and temperature-compensated values are computed outside the block and arrive as 16-bit inputs. The host has read-only access through a byte-wide port. Each 16-bit quantity is split into a low byte followed by a high byte. Reading a low byte freezes the matching high byte, so the two halves of a word always belong together. Reset is asynchronous on assertion and released through an internal synchronizer. On reset, the available-capacity count survives unless the RAM-integrity flag reports corruption.

Top module: `batt_cap_regs`

## Requirements
- R1: A cycle with `step_vld`=1 raises the available capacity (NAC) by exactly one when `step_up`=1 and lowers it by one when `step_up`=0. Without a step, NAC holds.
- R2: NAC saturates instead of wrapping. An up-step at 0xFFFF leaves 0xFFFF, and a down-step at 0 leaves 0.
- R3: While `charging`=0, `edv_final`=1 forces NAC to 0 on the next edge. This takes priority over any step in that cycle.
- R4: While reset is active, NAC is cleared if `ram_bad`=1 and keeps its value if `ram_bad`=0. All other state returns to 0.
- R5: While `charging`=1, the rate-compensated capacity (CACD) takes the NAC value of the previous cycle on each edge.
- R6: While `charging`=0, CACD becomes the smaller of its current value and `comp_cap`, so it never rises.
- R7: A discharged-amount counter counts down-steps and is cleared by a rising edge of `charging`. The learned capacity (LMD) loads this counter on a rising edge of `edv_first` only when `dq_ok`=1 and `charging`=0. Otherwise LMD holds.
- R8: State of charge (RSOC) is floor(100·NAC/LMD), clamped to 100, and is 0 when LMD is 0. It is refreshed by a restoring divider within 60 cycles of the operands settling, and never exceeds 100.
- R9: The host map is: RSOC at 0x0B, NAC at 0x0C/0x0D, CACD at 0x0E/0x0F, temperature-compensated capacity (CACT) at 0x10/0x11 and LMD at 0x12/0x13, with the low byte at the even address. `rd_data` shows the selected byte on the edge after `rd_en`=1 and holds when `rd_en`=0. Unmapped addresses read 0.
- R10: Reading a low byte captures the high byte of the same word. The next read of that word's high byte returns the captured value even if the word changed in between.
- R11: CACT takes `temp_cap` on each edge outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ram_bad | input | 1 | RAM corruption detected; clears NAC during reset |
| step_vld | input | 1 | One charge quantum this cycle |
| step_up | input | 1 | Step direction: 1 charge, 0 discharge |
| charging | input | 1 | Charging-status flag |
| edv_final | input | 1 | Battery voltage at or below final discharge threshold |
| edv_first | input | 1 | Battery voltage reached first end-of-discharge threshold |
| dq_ok | input | 1 | Discharge cycle qualifies for learning |
| comp_cap | input | 16 | Externally computed rate-compensated capacity |
| temp_cap | input | 16 | Externally computed temperature-compensated capacity |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host byte address |
| rd_data | output | 8 | Host read data, registered |

## Verification
The bench builds the block with its default parameters: a 100 percent full scale and a two-stage reset synchronizer, over the 16-bit capacity word. At this word width the upper saturation point is within reach of about 65,000 charge steps, so the bench drives NAC to 0xFFFF through the host-visible path instead of by preloading it. The 100 percent scale gives a 23-bit dividend. This lets the bench see both the clamp at 100 and exact truncated quotients such as 3000/170 within the refresh window. A second reset with the corruption flag low checks retention of a count at full scale.

// File: rtl/gauge_pkg.sv
package gauge_pkg;
  localparam int unsigned CAP_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] ADDR_PCT  = 8'h0B;
  localparam logic [7:0] ADDR_BASE = 8'h0C;
  localparam int unsigned N_WORDS  = 4;
  typedef logic [CAP_W-1:0] cap_t;
  typedef enum logic [1:0] {
    W_NAC  = 2'd0,
    W_CACD = 2'd1,
    W_CACT = 2'd2,
    W_LMD  = 2'd3
  } word_e;
endpackage

// File: rtl/gauge_cap_counter.sv
module gauge_cap_counter
  import gauge_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic ram_bad,
  input  logic step_vld,
  input  logic step_up,
  input  logic charging,
  input  logic edv_final,
  input  logic edv_first,
  input  logic dq_ok,
  output cap_t nac_o,
  output cap_t lmd_o
);
  localparam cap_t CAP_MAX = {CAP_W{1'b1}};

  cap_t nac_q, nac_d;
  cap_t acc_q, acc_d;
  cap_t lmd_q, lmd_d;
  logic chg_q, edv1_q;
  logic chg_rise, edv1_rise, lmd_ld, dsg_clr;

  assign chg_rise  = charging && !chg_q;
  assign edv1_rise = edv_first && !edv1_q;
  assign lmd_ld    = edv1_rise && dq_ok && !charging;
  assign dsg_clr   = edv_final && !charging;

  always_comb begin
    nac_d = nac_q;
    if (!rst_sn) begin
      if (ram_bad) nac_d = '0;
    end else if (dsg_clr) begin
      nac_d = '0;
    end else if (step_vld) begin
      if (step_up) nac_d = (nac_q == CAP_MAX) ? nac_q : nac_q + 1'b1;
      else         nac_d = (nac_q == '0)      ? nac_q : nac_q - 1'b1;
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (chg_rise)                                      acc_d = '0;
    else if (step_vld && !step_up && acc_q != CAP_MAX) acc_d = acc_q + 1'b1;
  end

  always_comb begin
    lmd_d = lmd_q;
    if (lmd_ld) lmd_d = acc_q;
  end

  // Count survives reset unless corruption is flagged, so it has no async clear.
  always_ff @(posedge clk) begin
    nac_q <= nac_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q  <= '0;
      lmd_q  <= '0;
      chg_q  <= 1'b0;
      edv1_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      lmd_q  <= lmd_d;
      chg_q  <= charging;
      edv1_q <= edv_first;
    end
  end

  assign nac_o = nac_q;
  assign lmd_o = lmd_q;

  p_step_up_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(step_vld && step_up && !dsg_clr) && $past(nac_q) != CAP_MAX)
      |-> nac_q == $past(nac_q) + 1'b1);

  p_step_dn_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(step_vld && !step_up && !dsg_clr) && $past(nac_q) != '0)
      |-> nac_q == $past(nac_q) - 1'b1);

  p_sat_hi_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(step_vld && step_up && !dsg_clr) && $past(nac_q) == CAP_MAX)
      |-> nac_q == CAP_MAX);

  p_edv_clear_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(edv_final && !charging)) |-> nac_q == '0);

  p_lmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(lmd_ld)) |-> $stable(lmd_q));
endmodule

// File: rtl/gauge_comp_track.sv
module gauge_comp_track
  import gauge_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic charging,
  input  cap_t nac,
  input  cap_t comp_cap,
  input  cap_t temp_cap,
  output cap_t cacd_o,
  output cap_t cact_o
);
  cap_t cacd_q, cacd_d;
  cap_t cact_q, cact_d;
  logic upd_en;

  assign upd_en = 1'b1;

  always_comb begin
    if (charging)               cacd_d = nac;
    else if (comp_cap < cacd_q) cacd_d = comp_cap;
    else                        cacd_d = cacd_q;
    cact_d = temp_cap;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cacd_q <= '0;
      cact_q <= '0;
    end else if (upd_en) begin
      cacd_q <= cacd_d;
      cact_q <= cact_d;
    end
  end

  assign cacd_o = cacd_q;
  assign cact_o = cact_q;

  p_track_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(charging)) |-> cacd_q == $past(nac));

  p_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(charging)) |-> cacd_q <= $past(cacd_q));

  p_temp_copy_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> cact_q == $past(temp_cap));
endmodule

// File: rtl/gauge_pct_div.sv
module gauge_pct_div
  import gauge_pkg::*;
#(
  parameter int unsigned PCT_MAX = 100,
  localparam int unsigned PCT_W  = $clog2(PCT_MAX + 1),
  localparam int unsigned DW     = CAP_W + PCT_W,
  localparam int unsigned CNT_W  = $clog2(DW)
)(
  input  logic             clk,
  input  logic             rst_sn,
  input  cap_t             nac,
  input  cap_t             lmd,
  output logic [PCT_W-1:0] pct_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  cap_t             rem_q, rem_d;
  cap_t             div_q, div_d;
  logic [DW-1:0]    dq_q, dq_d;
  logic [PCT_W-1:0] pct_q, pct_d;

  logic [DW-1:0]    prod;
  logic [CAP_W:0]   rem_sh, rem_sub;
  logic             ge;
  logic [DW-1:0]    dq_n;

  assign prod    = DW'(nac) * DW'(PCT_MAX);
  assign rem_sh  = {rem_q, dq_q[DW-1]};
  assign ge      = rem_sh >= {1'b0, div_q};
  assign rem_sub = rem_sh - {1'b0, div_q};
  assign dq_n    = {dq_q[DW-2:0], ge};

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    div_d  = div_q;
    dq_d   = dq_q;
    pct_d  = pct_q;
    if (!busy_q) begin
      dq_d   = prod;
      div_d  = lmd;
      rem_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else begin
      rem_d = CAP_W'(ge ? rem_sub : rem_sh);
      dq_d  = dq_n;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DW - 1)) begin
        busy_d = 1'b0;
        if (div_q == '0)                 pct_d = '0;
        else if (dq_n > DW'(PCT_MAX))    pct_d = PCT_W'(PCT_MAX);
        else                             pct_d = dq_n[PCT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      dq_q   <= '0;
      pct_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      div_q  <= div_d;
      dq_q   <= dq_d;
      pct_q  <= pct_d;
    end
  end

  assign pct_o = pct_q;

  p_pct_range_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    pct_q <= PCT_W'(PCT_MAX));

  p_pct_only_at_end_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(busy_q)) |-> $stable(pct_q));
endmodule

// File: rtl/gauge_host_port.sv
module gauge_host_port
  import gauge_pkg::*;
#(
  parameter int unsigned PCT_W = 7
)(
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               rd_en,
  input  logic [7:0]         rd_addr,
  input  logic [PCT_W-1:0]   pct,
  input  cap_t               nac,
  input  cap_t               cacd,
  input  cap_t               cact,
  input  cap_t               lmd,
  output logic [BYTE_W-1:0]  rd_data
);
  logic [BYTE_W-1:0] data_q, data_d;
  logic [BYTE_W-1:0] snap_q, snap_d;
  word_e             spair_q, spair_d;
  logic              svld_q, svld_d;

  logic [7:0]        off;
  logic              word_hit, hi_sel;
  word_e             widx;
  cap_t              word;

  assign off      = rd_addr - ADDR_BASE;
  assign word_hit = off < 8'(2 * N_WORDS);
  assign hi_sel   = rd_addr[0];
  assign widx     = word_e'(off[2:1]);

  always_comb begin
    unique case (widx)
      W_NAC:   word = nac;
      W_CACD:  word = cacd;
      W_CACT:  word = cact;
      default: word = lmd;
    endcase
  end

  always_comb begin
    data_d  = data_q;
    snap_d  = snap_q;
    spair_d = spair_q;
    svld_d  = svld_q;
    if (rd_en) begin
      if (rd_addr == ADDR_PCT) begin
        data_d = BYTE_W'(pct);
      end else if (word_hit) begin
        if (!hi_sel) begin
          data_d  = word[BYTE_W-1:0];
          snap_d  = word[CAP_W-1:BYTE_W];
          spair_d = widx;
          svld_d  = 1'b1;
        end else begin
          data_d = (svld_q && spair_q == widx) ? snap_q : word[CAP_W-1:BYTE_W];
          svld_d = 1'b0;
        end
      end else begin
        data_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      data_q  <= '0;
      snap_q  <= '0;
      spair_q <= W_NAC;
      svld_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      snap_q  <= snap_d;
      spair_q <= spair_d;
      svld_q  <= svld_d;
    end
  end

  assign rd_data = data_q;

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && !$past(rd_en)) |-> $stable(rd_data));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(rd_en) && $past(rd_addr) != ADDR_PCT && !$past(word_hit))
      |-> rd_data == '0);

  p_snap_armed_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(rst_sn) && $past(rd_en && word_hit && !hi_sel && rd_addr != ADDR_PCT))
      |-> svld_q);
endmodule

// File: rtl/batt_cap_regs.sv
module batt_cap_regs
  import gauge_pkg::*;
#(
  parameter int unsigned PCT_MAX   = 100,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned PCT_W    = $clog2(PCT_MAX + 1)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ram_bad,
  input  logic        step_vld,
  input  logic        step_up,
  input  logic        charging,
  input  logic        edv_final,
  input  logic        edv_first,
  input  logic        dq_ok,
  input  logic [15:0] comp_cap,
  input  logic [15:0] temp_cap,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data
);
  logic [RST_STAGES-1:0] rsync_q;
  logic                  rst_sn;
  cap_t                  nac, lmd, cacd, cact;
  logic [PCT_W-1:0]      pct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rsync_q[RST_STAGES-1];

  gauge_cap_counter u_cnt (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .ram_bad   (ram_bad),
    .step_vld  (step_vld),
    .step_up   (step_up),
    .charging  (charging),
    .edv_final (edv_final),
    .edv_first (edv_first),
    .dq_ok     (dq_ok),
    .nac_o     (nac),
    .lmd_o     (lmd)
  );

  gauge_comp_track u_comp (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .charging (charging),
    .nac      (nac),
    .comp_cap (comp_cap),
    .temp_cap (temp_cap),
    .cacd_o   (cacd),
    .cact_o   (cact)
  );

  gauge_pct_div #(.PCT_MAX(PCT_MAX)) u_div (
    .clk    (clk),
    .rst_sn (rst_sn),
    .nac    (nac),
    .lmd    (lmd),
    .pct_o  (pct)
  );

  gauge_host_port #(.PCT_W(PCT_W)) u_host (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .pct     (pct),
    .nac     (nac),
    .cacd    (cacd),
    .cact    (cact),
    .lmd     (lmd),
    .rd_data (rd_data)
  );
endmodule

// File: tb/batt_cap_regs_test.sv
module batt_cap_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_DIV   = 60;

  logic clk = 1'b0;
  logic rst_n, ram_bad, step_vld, step_up, charging, edv_final, edv_first, dq_ok, rd_en;
  logic [15:0] comp_cap, temp_cap;
  logic [7:0]  rd_addr, rd_data;

  int checks = 0;
  int errors = 0;
  int nac_m, acc_m, lmd_m;
  logic chg_m;

  // table entry: {up, count, expected NAC}
  localparam logic [32:0] TBL [5] = '{
    {1'b1, 16'd50, 16'd50},
    {1'b0, 16'd20, 16'd30},
    {1'b1, 16'd5,  16'd35},
    {1'b0, 16'd40, 16'd0},
    {1'b1, 16'd10, 16'd10}
  };

  batt_cap_regs uut (
    .clk(clk), .rst_n(rst_n), .ram_bad(ram_bad), .step_vld(step_vld), .step_up(step_up),
    .charging(charging), .edv_final(edv_final), .edv_first(edv_first), .dq_ok(dq_ok),
    .comp_cap(comp_cap), .temp_cap(temp_cap), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd8(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic rd16(input logic [7:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd8(a, lo);
    rd8(a + 8'd1, hi);
    d = {hi, lo};
  endtask

  task automatic steps(input logic up, input int n);
    @(negedge clk);
    charging = up; step_up = up; step_vld = 1'b1;
    if (up && !chg_m) acc_m = 0;
    chg_m = up;
    for (int i = 0; i < n; i++) begin
      if (up) nac_m = (nac_m == 65535) ? 65535 : nac_m + 1;
      else begin
        nac_m = (nac_m == 0) ? 0 : nac_m - 1;
        acc_m = (acc_m == 65535) ? 65535 : acc_m + 1;
      end
    end
    repeat (n) @(negedge clk);
    step_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic edv1(input logic ok);
    @(negedge clk); edv_first = 1'b1; dq_ok = ok;
    if (ok && !chg_m) lmd_m = acc_m;
    @(negedge clk); edv_first = 1'b0; dq_ok = 1'b0;
  endtask

  task automatic do_reset(input logic bad);
    @(negedge clk); rst_n = 1'b0; ram_bad = bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    if (bad) nac_m = 0;
    lmd_m = 0; acc_m = 0;
    chg_m = charging;
  endtask

  function automatic int exp_pct(input int n, input int l);
    int q;
    if (l == 0) return 0;
    q = (n * 100) / l;
    return (q > 100) ? 100 : q;
  endfunction

  initial begin
    logic [15:0] w;
    logic [7:0]  b;
    rst_n = 1'b0; ram_bad = 1'b1; step_vld = 1'b0; step_up = 1'b0; charging = 1'b0;
    edv_final = 1'b0; edv_first = 1'b0; dq_ok = 1'b0; rd_en = 1'b0; rd_addr = '0;
    comp_cap = 16'hFFFF; temp_cap = 16'h0000;
    nac_m = 0; acc_m = 0; lmd_m = 0; chg_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R4, R9)
    rd16(8'h0C, w); chk("R4 nac after corrupt reset", w, 0);
    rd16(8'h12, w); chk("R9 lmd reset", w, 0);
    rd8(8'h0B, b);  chk("R9 rsoc reset", b, 0);

    // stepping table (R1, R2)
    for (int i = 0; i < 5; i++) begin
      steps(TBL[i][32], int'(TBL[i][31:16]));
      rd16(8'h0C, w);
      chk((i == 3) ? "R2 low saturation" : "R1 step count", w, int'(TBL[i][15:0]));
      chk("R1 model agrees", nac_m, int'(TBL[i][15:0]));
    end

    // learning (R7, R8)
    steps(1'b1, 190);
    @(negedge clk); charging = 1'b0; chg_m = 1'b0;
    steps(1'b0, 60);
    edv1(1'b1);
    rd16(8'h12, w); chk("R7 lmd learned", w, 60);
    repeat (WAIT_DIV) @(negedge clk);
    rd8(8'h0B, b); chk("R8 rsoc clamp", b, exp_pct(nac_m, lmd_m));
    steps(1'b0, 110);
    rd16(8'h12, w); chk("R7 lmd holds without edge", w, 60);
    repeat (WAIT_DIV) @(negedge clk);
    rd8(8'h0B, b); chk("R8 rsoc 50", b, 50);
    edv1(1'b0);
    rd16(8'h12, w); chk("R7 unqualified ignored", w, 60);
    edv1(1'b1);
    rd16(8'h12, w); chk("R7 relearn", w, 170);
    repeat (WAIT_DIV) @(negedge clk);
    rd8(8'h0B, b); chk("R8 rsoc truncated", b, 17);

    // final-threshold clear, priority over an up-step (R3)
    @(negedge clk); edv_final = 1'b1; step_vld = 1'b1; step_up = 1'b1;
    @(negedge clk); edv_final = 1'b0; step_vld = 1'b0; nac_m = 0;
    rd16(8'h0C, w); chk("R3 final clear", w, 0);
    repeat (WAIT_DIV) @(negedge clk);
    rd8(8'h0B, b); chk("R8 rsoc zero nac", b, 0);

    // compensation tracking (R5, R6)
    steps(1'b1, 10);
    rd16(8'h0E, w); chk("R5 cacd follows nac", w, 10);
    @(negedge clk); charging = 1'b0; chg_m = 1'b0; comp_cap = 16'd8;
    repeat (2) @(negedge clk);
    rd16(8'h0E, w); chk("R6 cacd falls", w, 8);
    @(negedge clk); comp_cap = 16'd9;
    repeat (2) @(negedge clk);
    rd16(8'h0E, w); chk("R6 cacd no rise", w, 8);
    @(negedge clk); comp_cap = 16'd3;
    repeat (2) @(negedge clk);
    rd16(8'h0E, w); chk("R6 cacd min", w, 3);
    @(negedge clk); comp_cap = 16'hFFFF;

    // snapshot (R10)
    rd8(8'h0C, b); chk("R10 low byte", b, 10);
    steps(1'b1, 300);
    rd8(8'h0D, b); chk("R10 snapped high", b, 0);
    rd16(8'h0C, w); chk("R10 fresh word", w, 310);

    // top saturation (R2)
    steps(1'b1, 65600);
    rd16(8'h0C, w); chk("R2 high saturation", w, 65535);
    repeat (WAIT_DIV) @(negedge clk);
    rd8(8'h0B, b); chk("R8 rsoc full", b, 100);

    // map details (R9, R11)
    rd8(8'h05, b); chk("R9 unmapped", b, 0);
    rd8(8'h14, b); chk("R9 past end", b, 0);
    @(negedge clk); temp_cap = 16'h1234;
    repeat (2) @(negedge clk);
    rd16(8'h10, w); chk("R11 cact mirror", w, 16'h1234);

    // retention and corruption on reset (R4)
    do_reset(1'b0);
    rd16(8'h0C, w); chk("R4 nac retained", w, 65535);
    rd16(8'h12, w); chk("R4 lmd cleared", w, 0);
    repeat (WAIT_DIV) @(negedge clk);
    rd8(8'h0B, b); chk("R8 rsoc lmd zero", b, 0);
    do_reset(1'b1);
    rd16(8'h0C, w); chk("R4 nac cleared", w, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule